// File: doc/BRIEF.md
# Quad DAC Serial Register Interface

This block is the digital front end of a four-channel, 8-bit digital-to-analog converter. A host reaches it through a four-wire serial port: active-low chip select, serial clock, data in and data out. Each channel keeps two registers. The input register is loaded from the serial port. The DAC register drives the parallel converter code. A write can load one input register or all four at once. A transfer copies all four input registers into the DAC registers in the same cycle, so every output changes together. A transfer is started by a serial command, by the update bit of a write, or by a dedicated active-low load pin that runs apart from the serial traffic.

The host can read back any input register, most significant bit first or least significant bit first, to confirm that a word was latched. Every readback stream starts with a sticky power-fail flag. Reset sets this flag, and only an explicit clear command clears it. The serial pins are oversampled by the system clock through two-flop synchronizers. For this reason each serial-clock level and each chip-select level must last at least three system-clock cycles. The block can therefore take a serial clock of up to 10 MHz from a system clock well above 60 MHz.

Frames are 14 bits long and are sent most significant bit first. Bits [13:12] hold the opcode, [11:10] the channel, [9] the broadcast or order flag, [8] the update-now flag and [7:0] the data byte. Nothing in a frame takes effect until chip select rises.

Top module: `quad_dac_sif`

## Requirements
- R1: After reset the input and DAC registers are all zero, `dac_codes` reads 0, `pwr_fail` is 1, and `sdo_oe` and `sdo` are both 0.
- R2: A frame with opcode 2'b00 (write) loads data bits [7:0] into the input register chosen by bits [11:10] when bit 9 is 0. The other input registers and the DAC registers are left as they were, unless bit 8 requests an update.
- R3: A write with bit 9 set loads the data byte into all four input registers.
- R4: DAC registers change only on a transfer. A transfer copies all four input registers at once. It is started by opcode 2'b10, or by a write with bit 8 set, in which case the copy includes the byte just written.
- R5: A falling edge on `ld_n` copies all four input registers into the DAC registers, with no serial frame.
- R6: A frame that holds anything other than exactly 14 sampled bits when chip select rises is discarded, and every register keeps its value.
- R7: Opcode 2'b01 (readback) selects channel bits [11:10] and bit order bit 9 (0 = MSB first, 1 = LSB first). During the next frame, `sdo` shows the power-fail flag and then the 8 bits of that input register. Each bit is valid before a rising serial-clock edge and changes after a falling edge.
- R8: `pwr_fail` is set by reset, is not set again by any frame, and clears only on a frame with opcode 2'b11. Readback streams started after the clear show 0 as their first bit.
- R9: `sdo_oe` is 1 only while chip select is low, and `sdo` is 0 whenever `sdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| cs_n | input | 1 | Serial chip select, active low; a rising edge ends the frame |
| sck | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data in, sampled on rising `sck` |
| ld_n | input | 1 | Load pin; a falling edge transfers all input registers to the DAC registers |
| sdo | output | 1 | Serial readback data |
| sdo_oe | output | 1 | Output enable for `sdo` at the pad; 0 means high impedance |
| dac_codes | output | 32 | DAC register contents, channel n at bits [8n+7:8n] |
| pwr_fail | output | 1 | Sticky power-fail flag |

## Verification
Faults in the input registers stay hidden from the converter outputs until a transfer. The bench therefore reads back each register it has written, so a wrong byte, channel or bit order shows on `sdo` one frame later. A wrong transfer or a missed load edge shows on `dac_codes` within a few clocks of chip select rising or `ld_n` falling. The all-channel copy is checked against values that differ per channel. A bit counter that lets a short or long frame through corrupts the DAC or readback value at the next check. A flag that clears too early shows as the first bit of the next readback stream.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_READ  = 2'b01,
    OP_XFER  = 2'b10,
    OP_CLRPF = 2'b11
  } op_e;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      s1_q <= d;
      q    <= s1_q;
    end
  end
endmodule

// File: rtl/qdac_frame.sv
module qdac_frame #(
  parameter int DW = 8,
  parameter int FW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_act,
  input  logic          cs_fall,
  input  logic          cs_rise,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          sdi_q,
  input  logic [DW:0]   tx_word,
  output logic          frame_ok,
  output logic [FW-1:0] frame_bits,
  output logic          sdo,
  output logic          sdo_oe
);
  localparam int CW = $clog2(FW + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(FW);
  localparam logic [CW-1:0] CNT_SAT  = CW'(FW + 1);

  logic [FW-1:0] in_q, in_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW:0]   out_q, out_n;

  always_comb begin
    in_n  = in_q;
    cnt_n = cnt_q;
    out_n = out_q;
    if (cs_fall) begin
      in_n  = '0;
      cnt_n = '0;
      out_n = tx_word;
    end else if (cs_act) begin
      if (sck_rise) begin
        in_n = {in_q[FW-2:0], sdi_q};
        if (cnt_q != CNT_SAT) cnt_n = cnt_q + 1'b1;
      end
      if (sck_fall) out_n = {out_q[DW-1:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      cnt_q <= '0;
      out_q <= '0;
    end else begin
      in_q  <= in_n;
      cnt_q <= cnt_n;
      out_q <= out_n;
    end
  end

  assign frame_ok   = cs_rise && (cnt_q == CNT_FULL);
  assign frame_bits = in_q;
  assign sdo_oe     = cs_act;
  assign sdo        = cs_act & out_q[DW];
endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
  import qdac_pkg::*;
#(
  parameter int DW  = 8,
  parameter int NCH = 4,
  parameter int AW  = 2,
  parameter int FW  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_ok,
  input  logic [FW-1:0]     frame_bits,
  input  logic              ld_fall,
  output logic [NCH*DW-1:0] in_flat,
  output logic [NCH*DW-1:0] dac_flat,
  output logic              pf,
  output logic [AW-1:0]     rb_sel,
  output logic              rb_lsb,
  output logic              xfer
);
  op_e           op;
  logic [AW-1:0] addr;
  logic          flag9, upd;
  logic [DW-1:0] data;
  logic [DW-1:0] in_q [NCH];
  logic [DW-1:0] in_n [NCH];
  logic [DW-1:0] dac_q [NCH];
  logic [DW-1:0] dac_n [NCH];
  logic          pf_n, lsb_n;
  logic [AW-1:0] sel_n;

  assign op    = op_e'(frame_bits[FW-1:FW-2]);
  assign addr  = frame_bits[DW+2 +: AW];
  assign flag9 = frame_bits[DW+1];
  assign upd   = frame_bits[DW];
  assign data  = frame_bits[DW-1:0];

  always_comb begin
    xfer  = ld_fall;
    pf_n  = pf;
    sel_n = rb_sel;
    lsb_n = rb_lsb;
    for (int i = 0; i < NCH; i++) in_n[i] = in_q[i];
    if (frame_ok) begin
      unique case (op)
        OP_WRITE: begin
          for (int i = 0; i < NCH; i++)
            if (flag9 || (addr == AW'(i))) in_n[i] = data;
          if (upd) xfer = 1'b1;
        end
        OP_READ: begin
          sel_n = addr;
          lsb_n = flag9;
        end
        OP_XFER:  xfer = 1'b1;
        OP_CLRPF: pf_n = 1'b0;
      endcase
    end
    for (int i = 0; i < NCH; i++) dac_n[i] = xfer ? in_n[i] : dac_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        in_q[i]  <= '0;
        dac_q[i] <= '0;
      end
      pf     <= 1'b1;
      rb_sel <= '0;
      rb_lsb <= 1'b0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        in_q[i]  <= in_n[i];
        dac_q[i] <= dac_n[i];
      end
      pf     <= pf_n;
      rb_sel <= sel_n;
      rb_lsb <= lsb_n;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_flat
    assign in_flat[g*DW +: DW]  = in_q[g];
    assign dac_flat[g*DW +: DW] = dac_q[g];
  end
endmodule

// File: rtl/quad_dac_sif.sv
module quad_dac_sif #(
  parameter int DW  = 8,
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              ld_n,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [NCH*DW-1:0] dac_codes,
  output logic              pwr_fail
);
  localparam int AW = $clog2(NCH);
  localparam int FW = 2 + AW + 2 + DW;

  logic [1:0]        rst_sr;
  logic              rst_i_n;
  logic [3:0]        pin_q;
  logic [2:0]        edge_q;
  logic              cs_q, sck_q, ld_q, sdi_q;
  logic              cs_fall, cs_rise, sck_rise, sck_fall, ld_fall;
  logic              frame_ok, xfer, rb_lsb;
  logic [FW-1:0]     frame_bits;
  logic [NCH*DW-1:0] in_flat;
  logic [AW-1:0]     rb_sel;
  logic [DW-1:0]     sel_word, rev_word;
  logic [DW:0]       tx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr <= 2'b00;
    else        rst_sr <= {rst_sr[0], 1'b1};
  end
  assign rst_i_n = rst_sr[1];

  qdac_sync #(.W(4), .RST_VAL(4'b1010)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .d({cs_n, sck, ld_n, sdi}), .q(pin_q)
  );
  assign {cs_q, sck_q, ld_q, sdi_q} = pin_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) edge_q <= 3'b101;
    else          edge_q <= {cs_q, sck_q, ld_q};
  end
  assign cs_fall  = edge_q[2] & ~cs_q;
  assign cs_rise  = ~edge_q[2] & cs_q;
  assign sck_rise = ~edge_q[1] & sck_q;
  assign sck_fall = edge_q[1] & ~sck_q;
  assign ld_fall  = edge_q[0] & ~ld_q;

  always_comb begin
    sel_word = in_flat[rb_sel*DW +: DW];
    for (int i = 0; i < DW; i++) rev_word[i] = sel_word[DW-1-i];
    tx_word = {pwr_fail, rb_lsb ? rev_word : sel_word};
  end

  qdac_frame #(.DW(DW), .FW(FW)) u_frame (
    .clk(clk), .rst_n(rst_i_n), .cs_act(~cs_q), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sdi_q(sdi_q), .tx_word(tx_word), .frame_ok(frame_ok),
    .frame_bits(frame_bits), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  qdac_regs #(.DW(DW), .NCH(NCH), .AW(AW), .FW(FW)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .frame_ok(frame_ok), .frame_bits(frame_bits),
    .ld_fall(ld_fall), .in_flat(in_flat), .dac_flat(dac_codes),
    .pf(pwr_fail), .rb_sel(rb_sel), .rb_lsb(rb_lsb), .xfer(xfer)
  );
endmodule

// File: rtl/qdac_chk.sv
module qdac_chk #(
  parameter int DW  = 8,
  parameter int NCH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sdo_oe,
  input logic [NCH*DW-1:0] dac_codes,
  input logic [NCH*DW-1:0] in_flat,
  input logic              pwr_fail,
  input logic              frame_ok,
  input logic [1:0]        frame_op,
  input logic              xfer
);
  // R4
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_codes) |-> $past(xfer));

  // R2
  in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(in_flat) |-> ($past(frame_ok) && ($past(frame_op) == 2'b00)));

  // R8
  pf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_fail) |-> ($past(frame_ok) && ($past(frame_op) == 2'b11)));

  // R8
  pf_norise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(pwr_fail));

  // R9
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_oe);
endmodule

bind quad_dac_sif qdac_chk #(.DW(DW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo_oe(sdo_oe),
  .dac_codes(dac_codes), .in_flat(in_flat), .pwr_fail(pwr_fail),
  .frame_ok(frame_ok), .frame_op(frame_bits[FW-1:FW-2]), .xfer(xfer)
);

// File: tb/sim_quad_dac_sif.sv
`timescale 1ns/1ps
module sim_quad_dac_sif;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n, cs_n, sck, sdi, ld_n;
  logic        sdo, sdo_oe, pwr_fail;
  logic [31:0] dac_codes;

  quad_dac_sif u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .ld_n(ld_n),
    .sdo(sdo), .sdo_oe(sdo_oe), .dac_codes(dac_codes), .pwr_fail(pwr_fail)
  );

  always #2 clk = ~clk;

  typedef struct {
    string       req;
    int          kind;
    logic [31:0] val;
  } exp_t;

  exp_t        sb[$];
  event        settle;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;
  logic [8:0]  rx;
  logic        oe_seen;
  logic [7:0]  in_m [4];
  logic [7:0]  dac_m [4];
  logic        pf_m, lsb_m;
  int          sel_m;

  function automatic logic [31:0] dac_pack();
    return {dac_m[3], dac_m[2], dac_m[1], dac_m[0]};
  endfunction

  function automatic logic [8:0] rb_model();
    logic [7:0] w, r;
    w = in_m[sel_m];
    for (int i = 0; i < 8; i++) r[i] = w[7-i];
    return {pf_m, lsb_m ? r : w};
  endfunction

  // monitor: pops expectations and compares them with the ports
  initial begin
    forever begin
      @(settle);
      while (sb.size() > 0) begin
        exp_t e;
        logic [31:0] act;
        e = sb.pop_front();
        case (e.kind)
          0:       act = dac_codes;
          1:       act = {23'd0, rx};
          2:       act = {31'd0, pwr_fail};
          3:       act = {30'd0, sdo_oe, sdo};
          default: act = {31'd0, oe_seen};
        endcase
        checks++;
        if (act !== e.val) begin
          errors++;
          $display("FAIL %s kind %0d: actual %h expected %h", e.req, e.kind, act, e.val);
        end
      end
    end
  end

  task automatic expect_item(input string req, input int kind, input logic [31:0] val);
    exp_t e;
    e.req = req; e.kind = kind; e.val = val;
    sb.push_back(e);
  endtask

  task automatic flush();
    @(negedge clk);
    -> settle;
    @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] bits, input int n);
    rx = '0;
    oe_seen = 1'b0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    oe_seen = sdo_oe;
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      repeat (HALF) @(negedge clk);
      if (n - 1 - i < 9) rx[8 - (n - 1 - i)] = sdo;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic wr(input int ch, input logic [7:0] d, input bit bc, input bit upd);
    frame({2'b00, 2'b00, ch[1:0], bc, upd, d}, 14);
    for (int i = 0; i < 4; i++) if (bc || i == ch) in_m[i] = d;
    if (upd) for (int i = 0; i < 4; i++) dac_m[i] = in_m[i];
  endtask

  task automatic rd(input int ch, input bit lsb);
    frame({2'b00, 2'b01, ch[1:0], lsb, 9'd0}, 14);
    sel_m = ch;
    lsb_m = lsb;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] exp_rx;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0; ld_n = 1'b1;
    for (int i = 0; i < 4; i++) begin in_m[i] = '0; dac_m[i] = '0; end
    pf_m = 1'b1; lsb_m = 1'b0; sel_m = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    expect_item("R1 dac reset", 0, 32'd0);
    expect_item("R1 pf reset", 2, 32'd1);
    expect_item("R1 sdo idle", 3, 32'd0);
    flush();

    // R2 single write, no transfer yet
    wr(2, 8'hA5, 0, 0);
    expect_item("R2 R4 dac held after write", 0, dac_pack());
    flush();

    rd(2, 0);
    exp_rx = rb_model();
    rd(2, 0);
    expect_item("R7 readback msb first ch2", 1, {23'd0, exp_rx});
    expect_item("R9 oe during frame", 4, 32'd1);
    expect_item("R9 sdo idle after frame", 3, 32'd0);
    flush();

    // R4 transfer command
    frame({2'b00, 2'b10, 12'd0}, 14);
    for (int i = 0; i < 4; i++) dac_m[i] = in_m[i];
    expect_item("R4 transfer command", 0, dac_pack());
    flush();

    // R4 update-now write
    wr(0, 8'h3C, 0, 1);
    expect_item("R4 update-now write", 0, dac_pack());
    flush();

    // R7 lsb first
    wr(1, 8'h96, 0, 0);
    rd(1, 1);
    exp_rx = rb_model();
    rd(1, 0);
    expect_item("R7 readback lsb first ch1", 1, {23'd0, exp_rx});
    flush();
    exp_rx = rb_model();
    wr(3, 8'h11, 0, 0);
    expect_item("R7 readback msb first ch1", 1, {23'd0, exp_rx});
    expect_item("R2 dac unchanged by plain write", 0, dac_pack());
    flush();

    // R6 wrong bit counts
    frame({2'b00, 2'b00, 2'd1, 1'b1, 1'b1, 8'hFF}, 13);
    frame({2'b00, 2'b00, 2'd1, 1'b1, 1'b1, 8'hFF}, 15);
    frame({2'b00, 2'b11, 12'd0}, 13);
    expect_item("R6 short/long frames ignored dac", 0, dac_pack());
    expect_item("R6 short clear frame ignored pf", 2, {31'd0, pf_m});
    flush();
    exp_rx = rb_model();
    rd(1, 0);
    expect_item("R6 input reg untouched", 1, {23'd0, exp_rx});
    flush();

    // R3 broadcast, R5 load pin
    wr(0, 8'h5A, 1, 0);
    expect_item("R3 broadcast holds dac", 0, dac_pack());
    flush();
    ld_n = 1'b0;
    repeat (HALF) @(negedge clk);
    ld_n = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 4; i++) dac_m[i] = in_m[i];
    expect_item("R3 R5 load pin copies broadcast", 0, dac_pack());
    flush();

    // R8 clear flag
    frame({2'b00, 2'b11, 12'd0}, 14);
    pf_m = 1'b0;
    expect_item("R8 pf cleared", 2, 32'd0);
    flush();
    rd(3, 0);
    exp_rx = rb_model();
    wr(2, 8'hC3, 0, 1);
    expect_item("R8 readback leads with cleared flag", 1, {23'd0, exp_rx});
    expect_item("R4 final dac", 0, dac_pack());
    expect_item("R8 pf stays clear", 2, 32'd0);
    flush();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule